// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter with Parity

The block turns one byte at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, the eight data bits with bit 0 first, an optional parity bit, and a high stop interval. The line rests high between frames. Bit timing comes from a clock-enable input that pulses at sixteen times the bit rate. Each bit therefore lasts sixteen enabled cycles, and a half-bit stop period is a whole number of ticks.

A byte is offered with a valid/ready handshake. It is taken on a clock edge where both are high. The parity mode, stop length and rounding choice are captured on that same edge and hold for the whole frame. Ready stays low until the stop interval of the frame has fully elapsed, so the next start bit cannot cut into it. When 1.5 stop bits are selected, a rounding input can stretch the interval to a full two bits.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and between frames, txLine is high, inReady is 1 and busy is 0. A reset asserted in the middle of a frame returns the block to this state.
- R2: A byte is accepted on a rising clock edge where inValid and inReady are both 1. From the next cycle txLine is low (start bit), busy is 1 and inReady is 0. The start bit lasts 16 ticks.
- R3: The start bit is followed by the eight data bits, bit 0 first, each lasting 16 ticks.
- R4: parityMode 2'b01 selects even parity: the parity bit makes the number of ones across data and parity even. 2'b10 selects odd parity: that count is odd. 2'b00 and 2'b11 send no parity bit. A parity bit lasts 16 ticks and directly follows data bit 7.
- R5: The stop interval is high. Its length is selected by stopSel: 2'b00 gives 16 ticks, 2'b01 gives 24 ticks, and 2'b10 or 2'b11 give 32 ticks. inReady returns to 1 exactly when that many ticks of stop have elapsed.
- R6: When stopSel is 2'b01 and stopRoundUp is 1, the stop interval is 32 ticks. stopRoundUp has no effect for the other stopSel values.
- R7: Frame timing advances only on cycles where tickEn is 1. While tickEn is 0, txLine and busy hold their values.
- R8: inData, parityMode, stopSel and stopRoundUp are sampled only on the accepting edge. Changing them during a frame does not alter that frame.
- R9: inValid held high during a frame is not accepted until inReady returns to 1. A byte presented that way is then sent as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Clock enable at 16x the bit rate |
| inData | input | 8 | Byte to transmit |
| inValid | input | 1 | Byte offered |
| inReady | output | 1 | Block can accept a byte |
| parityMode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| stopSel | input | 2 | 00 one, 01 one and a half, 10/11 two stop bits |
| stopRoundUp | input | 1 | Stretch 1.5 stop bits to 2 |
| txLine | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that tickEn is a clean single-cycle enable, and that the producer treats inValid and inData as meaningful only against inReady. They also assume that configuration values outside a frame may be anything, since the block samples them only on acceptance. The stimulus changes every input at the falling clock edge. Most frames run with tickEn held high, so that bit boundaries fall on known cycles. A separate case holds tickEn low during a start bit. Configuration and data are deliberately scrambled during a frame, and inValid is held across a frame, to exercise the sampling and handshake rules.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic load;
    logic shiftData;
    logic sendParity;
    logic sendStop;
  } txStrobe_t;

endpackage

// File: rtl/uart_frame_tx_ctrl.sv
module uart_frame_tx_ctrl
  import uart_frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       inValid,
  input  logic [1:0] parityMode,
  input  logic [1:0] stopSel,
  input  logic       stopRoundUp,
  output txStrobe_t  strobe,
  output logic       inReady,
  output logic       busy
);

  localparam int CNT_W = $clog2(2 * OVS) + 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] STOP_ONE  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] STOP_HALF = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] STOP_TWO  = CNT_W'(2 * OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

  txState_e         state, stateNext;
  logic [CNT_W-1:0] tickCnt, tickCntNext;
  logic [IDX_W-1:0] bitIdx, bitIdxNext;
  logic             parEnQ;
  logic [CNT_W-1:0] stopLimQ;
  logic             accept;
  logic             bitEnd;
  logic             stopEnd;
  logic [CNT_W-1:0] stopLimIn;

  assign accept  = (state == ST_IDLE) && inValid;
  assign bitEnd  = tickEn && (tickCnt == BIT_LAST);
  assign stopEnd = tickEn && (tickCnt == stopLimQ);
  assign inReady = (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    unique case (stopSel)
      2'b00:   stopLimIn = STOP_ONE;
      2'b01:   stopLimIn = stopRoundUp ? STOP_TWO : STOP_HALF;
      default: stopLimIn = STOP_TWO;
    endcase
  end

  always_comb begin
    stateNext   = state;
    tickCntNext = tickEn ? tickCnt + 1'b1 : tickCnt;
    bitIdxNext  = bitIdx;
    strobe      = '0;
    unique case (state)
      ST_IDLE: begin
        tickCntNext = '0;
        if (accept) begin
          strobe.load = 1'b1;
          stateNext   = ST_START;
        end
      end
      ST_START: begin
        if (bitEnd) begin
          strobe.shiftData = 1'b1;
          stateNext        = ST_DATA;
          bitIdxNext       = '0;
          tickCntNext      = '0;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          tickCntNext = '0;
          if (bitIdx == IDX_LAST) begin
            if (parEnQ) begin
              strobe.sendParity = 1'b1;
              stateNext         = ST_PARITY;
            end else begin
              strobe.sendStop = 1'b1;
              stateNext       = ST_STOP;
            end
          end else begin
            strobe.shiftData = 1'b1;
            bitIdxNext       = bitIdx + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (bitEnd) begin
          strobe.sendStop = 1'b1;
          stateNext       = ST_STOP;
          tickCntNext     = '0;
        end
      end
      ST_STOP: begin
        if (stopEnd) begin
          stateNext   = ST_IDLE;
          tickCntNext = '0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      parEnQ   <= 1'b0;
      stopLimQ <= STOP_ONE;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      bitIdx  <= bitIdxNext;
      if (accept) begin
        parEnQ   <= (parityMode == 2'b01) || (parityMode == 2'b10);
        stopLimQ <= stopLimIn;
      end
    end
  end

  // R7: no tick, no progress
  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && state != ST_IDLE) |=> ($stable(state) && $stable(tickCnt)));

  // R5: tick counter never runs past the longest stop interval
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= STOP_TWO);

  // R3: datapath sees at most one strobe per cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R8: stop length is frozen while a frame runs
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(stopLimQ));

endmodule

// File: rtl/uart_frame_tx_dpath.sv
module uart_frame_tx_dpath
  import uart_frame_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [1:0]        parityMode,
  output logic              txLine
);

  logic [DATA_W-1:0] shReg;
  logic              parQ;
  logic              lineQ;
  logic              oddSel;

  assign oddSel = (parityMode == 2'b10);
  assign txLine = lineQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      parQ  <= 1'b0;
      lineQ <= 1'b1;
    end else if (strobe.load) begin
      shReg <= inData;
      parQ  <= (^inData) ^ oddSel;
      lineQ <= 1'b0;
    end else if (strobe.shiftData) begin
      lineQ <= shReg[0];
      shReg <= shReg >> 1;
    end else if (strobe.sendParity) begin
      lineQ <= parQ;
    end else if (strobe.sendStop) begin
      lineQ <= 1'b1;
    end
  end

  // R2: loading a byte always opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !txLine);

  // R5: entering the stop interval drives the line high
  a_r5_stop_high: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendStop |=> txLine);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        parityMode,
  input  logic [1:0]        stopSel,
  input  logic              stopRoundUp,
  output logic              txLine,
  output logic              busy
);

  txStrobe_t strobe;

  uart_frame_tx_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .inValid    (inValid),
    .parityMode (parityMode),
    .stopSel    (stopSel),
    .stopRoundUp(stopRoundUp),
    .strobe     (strobe),
    .inReady    (inReady),
    .busy       (busy)
  );

  uart_frame_tx_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .parityMode(parityMode),
    .txLine    (txLine)
  );

  // R1: line rests high whenever a byte can be taken
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> txLine);

  // R2: handshake starts a frame on the next cycle
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (!txLine && busy && !inReady));

  // R5: ready only returns after a high stop period
  a_r5_ready_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> (txLine && $past(txLine)));

  // R7: line is frozen while no tick arrives mid-frame
  a_r7_line_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tickEn && !(inValid && inReady)) |=> $stable(txLine));

endmodule

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [1:0] parityMode = '0;
  logic [1:0] stopSel = '0;
  logic       stopRoundUp = 1'b0;
  logic       txLine;
  logic       busy;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .inData(inData),
    .inValid(inValid), .inReady(inReady), .parityMode(parityMode),
    .stopSel(stopSel), .stopRoundUp(stopRoundUp), .txLine(txLine), .busy(busy)
  );

  // data, parityMode, stopSel, stopRoundUp
  localparam logic [12:0] VECS [8] = '{
    {8'hA5, 2'b00, 2'b00, 1'b0},
    {8'h3C, 2'b01, 2'b00, 1'b0},
    {8'h3D, 2'b01, 2'b01, 1'b0},
    {8'h81, 2'b10, 2'b10, 1'b0},
    {8'hFF, 2'b10, 2'b01, 1'b1},
    {8'h00, 2'b01, 2'b10, 1'b1},
    {8'h5A, 2'b11, 2'b11, 1'b0},
    {8'hC3, 2'b10, 2'b00, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // mode 0: plain, 1: scramble inputs mid-frame, 2: hold valid with d2
  task automatic sendFrame(input logic [7:0] d, input logic [1:0] pm,
                           input logic [1:0] ss, input logic rnd,
                           input int mode, input logic [7:0] d2);
    logic [9:0] expBits;
    int nb;
    int st;
    string bitTag;
    string stopTag;
    nb = ((pm == 2'b01) || (pm == 2'b10)) ? 10 : 9;
    st = (ss == 2'b00) ? 16 : ((ss == 2'b01) ? (rnd ? 32 : 24) : 32);
    stopTag = (rnd && ss == 2'b01) ? "R6" : "R5";
    expBits[0] = 1'b0;
    for (int i = 0; i < 8; i++) expBits[i+1] = d[i];
    expBits[9] = (pm == 2'b10) ? ~(^d) : (^d);
    while (!inReady) @(negedge clk);
    inData = d; parityMode = pm; stopSel = ss; stopRoundUp = rnd; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (mode == 1) begin
      inData = ~d;
      parityMode = (pm == 2'b01) ? 2'b10 : 2'b01;
      stopSel = (ss == 2'b00) ? 2'b10 : 2'b00;
      stopRoundUp = ~rnd;
      inValid = 1'b0;
    end else if (mode == 2) begin
      inData = d2;
      inValid = 1'b1;
    end else begin
      inValid = 1'b0;
    end
    chk("R2 busy after accept", busy, 1);
    chk("R2 ready after accept", inReady, 0);
    repeat (8) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      if (mode == 1) bitTag = "R8 bit";
      else if (b == 0) bitTag = "R2 start";
      else if (b <= 8) bitTag = "R3 data";
      else bitTag = "R4 parity";
      chk(bitTag, txLine, expBits[b]);
      if (mode == 2) chk("R9 ready low while busy", inReady, 0);
      if (b < nb - 1) repeat (16) @(negedge clk);
    end
    repeat (8 + st - 1) @(negedge clk);
    chk({stopTag, " stop line"}, txLine, 1);
    chk({stopTag, " ready before stop end"}, inReady, 0);
    @(negedge clk);
    chk({stopTag, " ready at stop end"}, inReady, 1);
    chk("R1 idle line", txLine, 1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset line", txLine, 1);
    chk("R1 reset ready", inReady, 1);
    chk("R1 reset busy", busy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle ready", inReady, 1);

    for (int v = 0; v < 8; v++) begin
      sendFrame(VECS[v][12:5], VECS[v][4:3], VECS[v][2:1], VECS[v][0], 0, 8'h00);
    end

    // R8: scrambled data and configuration during a frame
    sendFrame(8'h96, 2'b01, 2'b01, 1'b0, 1, 8'h00);
    sendFrame(8'h1E, 2'b10, 2'b00, 1'b1, 1, 8'h00);

    // R9: valid held across a frame, second byte follows
    sendFrame(8'h6B, 2'b01, 2'b00, 1'b0, 2, 8'hD4);
    sendFrame(8'hD4, 2'b01, 2'b00, 1'b0, 0, 8'h00);

    // R7: tick gating freezes the start bit
    while (!inReady) @(negedge clk);
    tickEn = 1'b0;
    inData = 8'h01; parityMode = 2'b00; stopSel = 2'b00; stopRoundUp = 1'b0;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    repeat (60) @(negedge clk);
    chk("R7 line held without tick", txLine, 0);
    chk("R7 busy held without tick", busy, 1);
    tickEn = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 start after ticks resume", txLine, 0);
    repeat (16) @(negedge clk);
    chk("R7 data bit 0 after 16 ticks", txLine, 1);

    // R1: reset in the middle of a frame
    repeat (20) @(negedge clk);
    chk("R1 mid-frame busy before reset", busy, 1);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid-frame reset line", txLine, 1);
    chk("R1 mid-frame reset ready", inReady, 1);
    chk("R1 mid-frame reset busy", busy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    sendFrame(8'hE7, 2'b10, 2'b01, 1'b0, 0, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule